// File: doc/BRIEF.md
# Virtual Address Region Decoder and Fault Classifier

This block sits between a core's load/store and fetch pipes and a unified translation lookaside buffer. For each request it takes the 32-bit virtual address, the access kind, the privilege level, the global translation enable and the lookup outcome already produced by the TLB array. It returns either a physical address with a write-permission flag or a fault with its exception code. The TLB storage is not part of the block. Its hit, multiple-hit, frame number, page size, protection and dirty fields arrive as inputs.

Two fixed windows of the address map skip translation. The window from 0x80000000 to 0xBFFFFFFF is folded onto the low 29 physical bits. The window from 0xE0000000 upward passes through unchanged. Unprivileged code may reach only the 64 MB slice starting at 0xE0000000 inside those windows. All other addresses go through the TLB result when translation is enabled. The block also keeps two pieces of state. The first is the 6-bit replacement pointer, which advances on every lookup that consults the TLB and wraps under a software-set bound. The second is the fault page register, which records the page number of the faulting address next to a software-written address-space identifier.

The response is registered. A request presented in one cycle produces its result on the outputs after the next rising clock edge.

Top module: `vfu_top`

## Requirements
- R1: A privileged access in 0x80000000..0xBFFFFFFF never faults. Its physical address is the virtual address ANDed with 0x1FFFFFFF, and write permission is granted.
- R2: A privileged access at or above 0xE0000000 never faults. Its physical address equals the virtual address, and write permission is granted.
- R3: An unprivileged access in either untranslated window outside 0xE0000000..0xE3FFFFFF faults with code 0x0E0 for a fetch (`req_kind`=00) or a read (01), and with 0x100 for a write (10). Inside that slice it behaves as in R2.
- R4: With `xlate_en` low, an address outside both untranslated windows never faults. It maps to the address ANDed with 0x1FFFFFFF, with write permission.
- R5: With translation on, a translatable address with `tlb_hit` low faults with 0x040 for a fetch or read and 0x060 for a write.
- R6: `tlb_multi` high on a translated access faults with 0x140, whatever the other TLB inputs are. It leaves `pteh_vpn` unchanged.
- R7: On a hit, an unprivileged access with `tlb_prot`[1] clear faults with 0x0A0 (fetch/read) or 0x0C0 (write). A privileged access ignores that bit.
- R8: On a hit, a write with `tlb_prot`[0] clear faults with 0x0C0. Otherwise a write with `tlb_dirty` clear faults with 0x080. The protection fault takes priority over the dirty fault.
- R9: On a clean hit, the physical address takes its upper bits from {`tlb_ppn`, 10'b0} and its page offset from the virtual address. The offset is 10, 12, 16 or 20 bits wide for `tlb_size` 0, 1, 2 or 3.
- R10: `rsp_can_write` is high on a clean hit only when `tlb_prot`[0] and `tlb_dirty` are both set. It is always low with a fault, in which case `rsp_paddr` is zero.
- R11: Every fault except 0x140 loads `pteh_vpn` with address bits 31:10. `pteh_asid` changes only through `asid_wr`.
- R12: `urc` resets to 0. It advances by one on each request that consults the TLB, meaning translation is on and the address is outside both untranslated windows. It returns to 0 when the incremented value exceeds a nonzero `urb_limit`, or exceeds 63. All other cycles hold it.
- R13: `rsp_valid` goes high exactly one cycle after `req_valid`. After reset, `rsp_valid`, `urc`, `pteh_vpn` and `pteh_asid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write (11 treated as read) |
| req_priv | input | 1 | 1 = privileged mode |
| xlate_en | input | 1 | Global translation enable |
| tlb_hit | input | 1 | TLB lookup found one entry |
| tlb_multi | input | 1 | TLB lookup found several entries |
| tlb_ppn | input | 19 | Physical frame number of the hit entry |
| tlb_size | input | 2 | Page size code of the hit entry |
| tlb_prot | input | 2 | Protection bits: [1] user access, [0] writable |
| tlb_dirty | input | 1 | Dirty bit of the hit entry |
| urb_limit | input | 6 | Replacement pointer bound (0 = no bound) |
| asid_wr | input | 1 | Load `pteh_asid` |
| asid_wdata | input | 8 | Address-space identifier to load |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 12 | Exception code (0 when no fault) |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_can_write | output | 1 | Write permission for the mapping |
| pteh_vpn | output | 22 | Captured faulting page number |
| pteh_asid | output | 8 | Held address-space identifier |
| urc | output | 6 | Replacement pointer |

## Verification
Two conditions are hard to reach from the ports. The first is the replacement pointer wrapping at 63 with no bound. The bench reaches it by issuing a long unbroken run of TLB-consulting misses while a bench-side model tracks the expected pointer. The second is a bound crossing, reached by switching `urb_limit` to a value below the current pointer. The fault page register is checked after every vector, so a multiple-hit fault that follows another fault shows whether the register was wrongly overwritten. Priority between stacked fault causes is covered by giving one entry both a cleared writable bit and a cleared dirty bit.

// File: rtl/vfu_pkg.sv
// Shared constants and types for the address region decoder and fault
// classifier. Assumes a 32-bit virtual address and a 29-bit physical space.
package vfu_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int CODE_W = 12;
    localparam int PG_MIN = 10;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    localparam logic [CODE_W-1:0] EXC_NONE     = 12'h000;
    localparam logic [CODE_W-1:0] EXC_RD_MISS  = 12'h040;
    localparam logic [CODE_W-1:0] EXC_WR_MISS  = 12'h060;
    localparam logic [CODE_W-1:0] EXC_FIRST_WR = 12'h080;
    localparam logic [CODE_W-1:0] EXC_RD_PROT  = 12'h0A0;
    localparam logic [CODE_W-1:0] EXC_WR_PROT  = 12'h0C0;
    localparam logic [CODE_W-1:0] EXC_RD_ADDR  = 12'h0E0;
    localparam logic [CODE_W-1:0] EXC_WR_ADDR  = 12'h100;
    localparam logic [CODE_W-1:0] EXC_MULTI    = 12'h140;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [VA_W-1:0]   paddr;
        logic              can_wr;
    } xres_t;

    // Page offset width for a given page size code.
    function automatic int page_bits(input int sz);
        case (sz)
            0:       return 10;
            1:       return 12;
            2:       return 16;
            default: return 20;
        endcase
    endfunction

endpackage

// File: rtl/vfu_region.sv
// Fixed-region decoder. Classifies a virtual address into the folded
// window, the pass-through window or the translatable space, and flags
// unprivileged accesses that the untranslated windows refuse.
// Assumes VA_W >= 6 and PA_W < VA_W.
module vfu_region #(
    parameter int VA_W = 32,
    parameter int PA_W = 29
) (
    input  logic [VA_W-1:0] va,
    input  logic            priv,
    output logic            needs_map,
    output logic            deny,
    output logic [VA_W-1:0] direct_pa
);
    localparam int ZPAD = VA_W - PA_W;

    logic fold_win;
    logic pass_win;
    logic user_slice;

    // Decode the top address bits into region membership.
    always_comb begin
        fold_win   = (va[VA_W-1 -: 2] == 2'b10);
        pass_win   = (va[VA_W-1 -: 3] == 3'b111);
        user_slice = (va[VA_W-1 -: 6] == 6'b111000);
        needs_map  = !(fold_win || pass_win);
        deny       = (fold_win || pass_win) && !priv && !(pass_win && user_slice);
        direct_pa  = fold_win ? {{ZPAD{1'b0}}, va[PA_W-1:0]} : va;
    end

endmodule

// File: rtl/vfu_tlb_check.sv
// Classifies a TLB lookup outcome into a fault code or a physical
// address. The page-size candidates are built by a generate loop.
// Assumes PA_W == PPN_W + PG_MIN and inputs are stable for the cycle.
module vfu_tlb_check
    import vfu_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PPN_W = 19,
    parameter int SZ_W  = 2
) (
    input  logic [VA_W-1:0]  va,
    input  logic             is_wr,
    input  logic             priv,
    input  logic             hit,
    input  logic             multi,
    input  logic [PPN_W-1:0] ppn,
    input  logic [SZ_W-1:0]  size,
    input  logic [1:0]       prot,
    input  logic             dirty,
    output xres_t            res
);
    localparam int NSZ  = 1 << SZ_W;
    localparam int PW   = PPN_W + PG_MIN;
    localparam int ZPAD = VA_W - PW;

    logic [PW-1:0] frame_base;
    logic [PW-1:0] cand [NSZ];

    assign frame_base = {ppn, {PG_MIN{1'b0}}};

    // One physical address candidate per page size.
    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int OB = page_bits(s);
        localparam logic [PW-1:0] OFF_MASK = PW'((64'd1 << OB) - 64'd1);
        assign cand[s] = (frame_base & ~OFF_MASK) | (va[PW-1:0] & OFF_MASK);
    end

    // Apply fault causes in priority order, then select the mapping.
    always_comb begin
        res = '0;
        if (multi) begin
            res.fault = 1'b1;
            res.code  = EXC_MULTI;
        end else if (!hit) begin
            res.fault = 1'b1;
            res.code  = is_wr ? EXC_WR_MISS : EXC_RD_MISS;
        end else if (!priv && !prot[1]) begin
            res.fault = 1'b1;
            res.code  = is_wr ? EXC_WR_PROT : EXC_RD_PROT;
        end else if (is_wr && !prot[0]) begin
            res.fault = 1'b1;
            res.code  = EXC_WR_PROT;
        end else if (is_wr && !dirty) begin
            res.fault = 1'b1;
            res.code  = EXC_FIRST_WR;
        end else begin
            res.paddr  = {{ZPAD{1'b0}}, cand[size]};
            res.can_wr = prot[0] && dirty;
        end
    end

endmodule

// File: rtl/vfu_state.sv
// Holds the replacement pointer and the fault page register.
// Assumes URC_W <= 8 so the bound comparison stays narrow.
module vfu_state #(
    parameter int URC_W  = 6,
    parameter int VPN_W  = 22,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [URC_W-1:0]  bound,
    input  logic              capture,
    input  logic [VPN_W-1:0]  cap_vpn,
    input  logic              asid_wr,
    input  logic [ASID_W-1:0] asid_wdata,
    output logic [URC_W-1:0]  urc,
    output logic [VPN_W-1:0]  vpn_q,
    output logic [ASID_W-1:0] asid_q
);
    logic [URC_W:0]   urc_inc;
    logic             urc_wrap;
    logic [URC_W-1:0] urc_nx;

    // Next pointer value with bound and overflow wrap.
    always_comb begin
        urc_inc  = {1'b0, urc} + 1'b1;
        urc_wrap = ((bound != '0) && (urc_inc > {1'b0, bound})) || urc_inc[URC_W];
        urc_nx   = urc_wrap ? '0 : urc_inc[URC_W-1:0];
    end

    // Replacement pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)    urc <= '0;
        else if (step) urc <= urc_nx;
    end

    // Fault page number register.
    always_ff @(posedge clk) begin
        if (!rst_n)       vpn_q <= '0;
        else if (capture) vpn_q <= cap_vpn;
    end

    // Address-space identifier, written only by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       asid_q <= '0;
        else if (asid_wr) asid_q <= asid_wdata;
    end

endmodule

// File: rtl/vfu_top.sv
// Address region decoder and fault classifier. Combines the fixed-region
// decode, the translation enable and the TLB outcome into one registered
// response, and updates the replacement pointer and fault page register.
// Assumes the TLB inputs describe the lookup of req_vaddr in the same cycle.
module vfu_top
    import vfu_pkg::*;
#(
    parameter int PPN_W  = 19,
    parameter int SZ_W   = 2,
    parameter int URC_W  = 6,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic              xlate_en,
    input  logic              tlb_hit,
    input  logic              tlb_multi,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [SZ_W-1:0]   tlb_size,
    input  logic [1:0]        tlb_prot,
    input  logic              tlb_dirty,
    input  logic [URC_W-1:0]  urb_limit,
    input  logic              asid_wr,
    input  logic [ASID_W-1:0] asid_wdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_paddr,
    output logic              rsp_can_write,
    output logic [21:0]       pteh_vpn,
    output logic [ASID_W-1:0] pteh_asid,
    output logic [URC_W-1:0]  urc
);
    localparam int VPN_W = VA_W - PG_MIN;
    localparam int ZPAD  = VA_W - PA_W;

    logic            is_wr;
    logic            needs_map;
    logic            deny;
    logic [VA_W-1:0] direct_pa;
    xres_t           tlb_res;
    xres_t           res;
    logic            tlb_consult;
    logic            capture;

    assign is_wr = (acc_e'(req_kind) == ACC_WRITE);

    vfu_region #(.VA_W(VA_W), .PA_W(PA_W)) u_region (
        .va        (req_vaddr),
        .priv      (req_priv),
        .needs_map (needs_map),
        .deny      (deny),
        .direct_pa (direct_pa)
    );

    vfu_tlb_check #(.VA_W(VA_W), .PPN_W(PPN_W), .SZ_W(SZ_W)) u_check (
        .va    (req_vaddr),
        .is_wr (is_wr),
        .priv  (req_priv),
        .hit   (tlb_hit),
        .multi (tlb_multi),
        .ppn   (tlb_ppn),
        .size  (tlb_size),
        .prot  (tlb_prot),
        .dirty (tlb_dirty),
        .res   (tlb_res)
    );

    // Choose between region fault, direct mapping, flat mapping and TLB result.
    always_comb begin
        res = '0;
        if (deny) begin
            res.fault = 1'b1;
            res.code  = is_wr ? EXC_WR_ADDR : EXC_RD_ADDR;
        end else if (!needs_map) begin
            res.paddr  = direct_pa;
            res.can_wr = 1'b1;
        end else if (!xlate_en) begin
            res.paddr  = {{ZPAD{1'b0}}, req_vaddr[PA_W-1:0]};
            res.can_wr = 1'b1;
        end else begin
            res = tlb_res;
        end
    end

    // State update strobes for the pointer and the fault page register.
    always_comb begin
        tlb_consult = req_valid && needs_map && xlate_en;
        capture     = req_valid && res.fault && (res.code != EXC_MULTI);
    end

    vfu_state #(.URC_W(URC_W), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (tlb_consult),
        .bound      (urb_limit),
        .capture    (capture),
        .cap_vpn    (req_vaddr[VA_W-1:PG_MIN]),
        .asid_wr    (asid_wr),
        .asid_wdata (asid_wdata),
        .urc        (urc),
        .vpn_q      (pteh_vpn),
        .asid_q     (pteh_asid)
    );

    // Response strobe register.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Response data register, loaded with each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault     <= 1'b0;
            rsp_code      <= '0;
            rsp_paddr     <= '0;
            rsp_can_write <= 1'b0;
        end else if (req_valid) begin
            rsp_fault     <= res.fault;
            rsp_code      <= res.code;
            rsp_paddr     <= res.paddr;
            rsp_can_write <= res.can_wr;
        end
    end

endmodule

// File: rtl/vfu_sva.sv
// Property checker for vfu_top, attached by the bind below.
module vfu_sva
    import vfu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        asid_wr,
    input logic        tlb_consult,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [11:0] rsp_code,
    input logic        rsp_can_write,
    input logic [21:0] pteh_vpn,
    input logic [7:0]  pteh_asid,
    input logic [5:0]  urc
);

    assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_urc_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_consult |=> (urc == 6'd0 || urc == $past(urc) + 6'd1));

    assert_urc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !tlb_consult |=> $stable(urc));

    assert_multi_keeps_vpn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == EXC_MULTI) |-> $stable(pteh_vpn));

    assert_fault_vpn_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault && rsp_code != EXC_MULTI) |-> (pteh_vpn == $past(req_vaddr[31:10])));

    assert_asid_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !asid_wr |=> $stable(pteh_asid));

    assert_fault_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_can_write);

    assert_addr_err_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == EXC_WR_ADDR) |-> ($past(req_kind) == 2'b10));

endmodule

bind vfu_top vfu_sva u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .asid_wr       (asid_wr),
    .tlb_consult   (tlb_consult),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_code      (rsp_code),
    .rsp_can_write (rsp_can_write),
    .pteh_vpn      (pteh_vpn),
    .pteh_asid     (pteh_asid),
    .urc           (urc)
);

// File: tb/sim_vfu_top.sv
`timescale 1ns/1ps
module sim_vfu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        xlate_en = 1'b0;
    logic        tlb_hit = 1'b0;
    logic        tlb_multi = 1'b0;
    logic [18:0] tlb_ppn = '0;
    logic [1:0]  tlb_size = '0;
    logic [1:0]  tlb_prot = '0;
    logic        tlb_dirty = 1'b0;
    logic [5:0]  urb_limit = '0;
    logic        asid_wr = 1'b0;
    logic [7:0]  asid_wdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [11:0] rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_can_write;
    logic [21:0] pteh_vpn;
    logic [7:0]  pteh_asid;
    logic [5:0]  urc;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    vfu_top u0 (.*);

    localparam logic [1:0] KF = 2'd0, KR = 2'd1, KW = 2'd2;

    typedef struct packed {
        logic [1:0]  kind;
        logic        priv;
        logic        at;
        logic        hit;
        logic        multi;
        logic [1:0]  sz;
        logic [1:0]  prot;
        logic        dirty;
        logic [31:0] va;
        logic [18:0] ppn;
        logic        ef;
        logic [11:0] ecode;
        logic [31:0] epa;
        logic        ewr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{KR,1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'h8123_4567,19'h0,1'b0,12'h000,32'h0123_4567,1'b1,4'd1},   // R1
        '{KW,1'b1,1'b1,1'b1,1'b0,2'd0,2'd0,1'b0,32'hA765_4321,19'h0,1'b0,12'h000,32'h0765_4321,1'b1,4'd1},   // R1
        '{KR,1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'hFF00_0010,19'h0,1'b0,12'h000,32'hFF00_0010,1'b1,4'd2},   // R2
        '{KR,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'h8000_0000,19'h0,1'b1,12'h0E0,32'h0,1'b0,4'd3},           // R3
        '{KW,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'hA000_0000,19'h0,1'b1,12'h100,32'h0,1'b0,4'd3},           // R3
        '{KF,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'hE400_0000,19'h0,1'b1,12'h0E0,32'h0,1'b0,4'd3},           // R3
        '{KW,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'hE3FF_FFFC,19'h0,1'b0,12'h000,32'hE3FF_FFFC,1'b1,4'd3},   // R3
        '{KW,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'hC123_4567,19'h0,1'b0,12'h000,32'h0123_4567,1'b1,4'd4},   // R4
        '{KR,1'b0,1'b0,1'b0,1'b0,2'd0,2'd0,1'b0,32'h7FFF_FFFF,19'h0,1'b0,12'h000,32'h1FFF_FFFF,1'b1,4'd4},   // R4
        '{KR,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0000_1000,19'h0,1'b1,12'h040,32'h0,1'b0,4'd5},           // R5
        '{KW,1'b1,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0000_2000,19'h0,1'b1,12'h060,32'h0,1'b0,4'd5},           // R5
        '{KF,1'b0,1'b1,1'b0,1'b0,2'd0,2'd0,1'b0,32'h0000_3000,19'h0,1'b1,12'h040,32'h0,1'b0,4'd5},           // R5
        '{KR,1'b1,1'b1,1'b1,1'b1,2'd1,2'd3,1'b1,32'h0000_4000,19'h0,1'b1,12'h140,32'h0,1'b0,4'd6},           // R6
        '{KR,1'b0,1'b1,1'b1,1'b0,2'd1,2'd0,1'b1,32'h0000_5000,19'h0,1'b1,12'h0A0,32'h0,1'b0,4'd7},           // R7
        '{KW,1'b0,1'b1,1'b1,1'b0,2'd1,2'd1,1'b1,32'h0000_5400,19'h0,1'b1,12'h0C0,32'h0,1'b0,4'd7},           // R7
        '{KR,1'b1,1'b1,1'b1,1'b0,2'd1,2'd0,1'b0,32'h0000_6123,19'h7FFFF,1'b0,12'h000,32'h1FFF_F123,1'b0,4'd7}, // R7
        '{KW,1'b1,1'b1,1'b1,1'b0,2'd1,2'd2,1'b1,32'h0000_7000,19'h0,1'b1,12'h0C0,32'h0,1'b0,4'd8},           // R8
        '{KW,1'b1,1'b1,1'b1,1'b0,2'd1,2'd3,1'b0,32'h0000_8000,19'h0,1'b1,12'h080,32'h0,1'b0,4'd8},           // R8
        '{KW,1'b1,1'b1,1'b1,1'b0,2'd1,2'd2,1'b0,32'h0000_9000,19'h0,1'b1,12'h0C0,32'h0,1'b0,4'd8},           // R8
        '{KR,1'b1,1'b1,1'b1,1'b0,2'd0,2'd3,1'b1,32'h1234_5ABC,19'h7FFFF,1'b0,12'h000,32'h1FFF_FEBC,1'b1,4'd9}, // R9
        '{KR,1'b1,1'b1,1'b1,1'b0,2'd1,2'd3,1'b1,32'h1234_5ABC,19'h7FFFF,1'b0,12'h000,32'h1FFF_FABC,1'b1,4'd9}, // R9
        '{KR,1'b1,1'b1,1'b1,1'b0,2'd2,2'd3,1'b1,32'h1234_5ABC,19'h7FFFF,1'b0,12'h000,32'h1FFF_5ABC,1'b1,4'd9}, // R9
        '{KR,1'b0,1'b1,1'b1,1'b0,2'd3,2'd3,1'b1,32'h1234_5ABC,19'h7FFFF,1'b0,12'h000,32'h1FF4_5ABC,1'b1,4'd9}, // R9
        '{KW,1'b0,1'b1,1'b1,1'b0,2'd1,2'd3,1'b1,32'h4000_0ABC,19'h00001,1'b0,12'h000,32'h0000_0ABC,1'b1,4'd10}, // R10
        '{KR,1'b0,1'b1,1'b1,1'b0,2'd1,2'd3,1'b0,32'h4000_0ABC,19'h00001,1'b0,12'h000,32'h0000_0ABC,1'b0,4'd10}  // R10
    };

    logic [5:0]  exp_urc = '0;
    logic [21:0] exp_vpn = '0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
        end
    endtask

    function automatic logic [5:0] urc_step(input logic [5:0] u, input logic [5:0] b);
        logic [6:0] n;
        n = {1'b0, u} + 7'd1;
        if ((b != 6'd0 && n > {1'b0, b}) || n[6]) return 6'd0;
        return n[5:0];
    endfunction

    function automatic bit consults(input logic [31:0] va, input logic at);
        return at && !(va[31:30] == 2'b10) && !(va[31:29] == 3'b111);
    endfunction

    // Apply one vector, check the registered response one cycle later.
    task automatic run_vec(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.rq);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v.va; req_kind = v.kind; req_priv = v.priv;
        xlate_en = v.at; tlb_hit = v.hit; tlb_multi = v.multi; tlb_ppn = v.ppn;
        tlb_size = v.sz; tlb_prot = v.prot; tlb_dirty = v.dirty;
        @(negedge clk);
        req_valid = 1'b0;
        if (consults(v.va, v.at)) exp_urc = urc_step(exp_urc, urb_limit);
        if (v.ef && v.ecode != 12'h140) exp_vpn = v.va[31:10];
        chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(v.ef));
        chk({tag, " code"}, 32'(rsp_code), 32'(v.ecode));
        chk({tag, " paddr"}, rsp_paddr, v.epa);
        chk({tag, " can_write"}, 32'(rsp_can_write), 32'(v.ewr));
        chk("R12 urc", 32'(urc), 32'(exp_urc));
        chk("R11 pteh_vpn", 32'(pteh_vpn), 32'(exp_vpn));
    endtask

    // One TLB-consulting miss read, then urc check.
    task automatic consult_once();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_1000; req_kind = KR; req_priv = 1'b1;
        xlate_en = 1'b1; tlb_hit = 1'b0; tlb_multi = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        exp_urc = urc_step(exp_urc, urb_limit);
        chk("R12 urc wrap", 32'(urc), 32'(exp_urc));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R13 reset urc", 32'(urc), 32'd0);
        chk("R13 reset pteh_vpn", 32'(pteh_vpn), 32'd0);
        chk("R13 reset pteh_asid", 32'(pteh_asid), 32'd0);
        // R11 load identifier
        asid_wr = 1'b1; asid_wdata = 8'h5A;
        @(negedge clk);
        asid_wr = 1'b0;
        chk("R11 asid load", 32'(pteh_asid), 32'h5A);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R11 faults left the identifier alone
        chk("R11 asid kept", 32'(pteh_asid), 32'h5A);
        // R13 idle cycle gives no response
        @(negedge clk);
        chk("R13 idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R12 bounded wrap
        urb_limit = 6'd2;
        for (int i = 0; i < 5; i++) consult_once();
        // R12 unbounded wrap past 63
        urb_limit = 6'd0;
        for (int i = 0; i < 70; i++) consult_once();

        // R13 reset clears state again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R13 re-reset urc", 32'(urc), 32'd0);
        chk("R13 re-reset asid", 32'(pteh_asid), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule